// File: doc/BRIEF.md
# Subroutine Call/Return Stack Sequencer

This block sequences the program counter of a small 8-bit processor and gives it subroutine support. A hardware stack pointer addresses a short region of stack memory held inside the block. Each clock cycle the block takes one command code: idle, sequential step, jump, call, return, push or pop. A target address and a data byte come with the command. Every command completes on a single rising clock edge.

The stack grows toward lower addresses and holds a fixed number of entries. A call saves the address that follows the calling instruction, then moves the PC to the target. A return reloads the PC from the saved entry. Pushes that would pass the bottom of the stack, and pops from an empty stack, are refused and raise sticky flags. The memory address output shows which pointer is in use: the PC for normal sequencing, the stack pointer for stack traffic.

A mode input switches call and return over to a single link register, with no stack involved. In this mode a nested call overwrites the only saved return address, so the outer return is lost.

Top module: `callstack_seq`

## Requirements
- R1: When a synchronous, active-high reset is applied, the block sets PC to 0x00, sets SP to its empty value 0xF0, and clears the overflow flag, the underflow flag, the data output and the link register.
- R2: PUSH (cmd 5) first lowers SP by one and then writes the data byte at the new SP. The first push after reset therefore lands at 0xEF.
- R3: POP (cmd 6) places the entry at SP on the data output after the edge and then raises SP by one. Values come back last-in, first-out: pushing 7, 3, 9 and 5 and then popping four times yields 5, 9, 3, 7.
- R4: With link mode low, CALL (cmd 3) pushes PC+1 the same way as a push and loads the target into the PC.
- R5: With link mode low, RET (cmd 4) pops the top entry and loads it into the PC.
- R6: The stack holds six entries, from 0xEF down to 0xEA. A PUSH or stack CALL made while SP is 0xEA is suppressed: SP, PC and the stored entries stay unchanged. The overflow flag is set and stays set until reset.
- R7: A POP or stack RET made while SP is 0xF0 sets the underflow flag, which stays set until reset. SP, PC and the data output stay unchanged.
- R8: The memory address output is combinational. It equals SP-1 during PUSH or stack CALL, SP during POP or stack RET, and PC for every other command.
- R9: STEP (cmd 1) adds one to the PC, wrapping from 0xFF to 0x00. JMP (cmd 2) loads the target. NOP (cmd 0) changes nothing.
- R10: With link mode high, CALL writes PC+1 into the link register and loads the target, and RET loads the link register into the PC. SP is untouched in both cases. After two nested calls, both returns go to the inner return address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command code (0 NOP, 1 STEP, 2 JMP, 3 CALL, 4 RET, 5 PUSH, 6 POP) |
| link_mode | input | 1 | High: call/return use the single link register |
| target | input | ADDR_W | Jump or call destination |
| din | input | DATA_W | Byte stored by PUSH |
| pc | output | ADDR_W | Program counter |
| sp | output | ADDR_W | Stack pointer |
| mem_addr | output | ADDR_W | Memory address: PC or stack-derived |
| dout | output | DATA_W | Last byte returned by POP |
| lr | output | ADDR_W | Link register |
| overflow | output | 1 | Sticky stack overflow flag |
| underflow | output | 1 | Sticky stack underflow flag |

## Verification
The assertions assume three things about the inputs. Exactly one command code in the range 0 to 6 is presented per cycle. Inputs are stable around each rising edge. The address and data widths are equal, so a return address fits in a stack cell. The bench keeps to these assumptions by driving every input on the falling edge and using only the seven defined codes.

The bench covers every call nesting depth from one to seven, which includes the overflowing seventh. It also covers a full 256-value PC wrap and a long arithmetic sequence of mixed commands with the mode toggling. Each result is compared with a model built from the requirements.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_STEP = 3'd1,
    CMD_JMP  = 3'd2,
    CMD_CALL = 3'd3,
    CMD_RET  = 3'd4,
    CMD_PUSH = 3'd5,
    CMD_POP  = 3'd6
  } cmd_e;
endpackage

// File: rtl/cs_stack_ptr.sv
module cs_stack_ptr #(
  parameter int ADDR_W   = 8,
  parameter int DEPTH    = 6,
  parameter int TOP_CELL = 239
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic              pop_req,
  output logic [ADDR_W-1:0] sp,
  output logic              push_ok,
  output logic              pop_ok,
  output logic              ovf,
  output logic              unf
);
  localparam logic [ADDR_W-1:0] EMPTY_SP = ADDR_W'(TOP_CELL + 1);
  localparam logic [ADDR_W-1:0] FULL_SP  = ADDR_W'(TOP_CELL - DEPTH + 1);

  assign push_ok = push_req && (sp != FULL_SP);
  assign pop_ok  = pop_req  && (sp != EMPTY_SP);

  always_ff @(posedge clk) begin
    if (rst) begin
      sp  <= EMPTY_SP;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      if (push_ok)       sp <= sp - 1'b1;
      else if (pop_ok)   sp <= sp + 1'b1;
      if (push_req && !push_ok) ovf <= 1'b1;
      if (pop_req && !pop_ok)   unf <= 1'b1;
    end
  end

  assert_sp_bounds_R6: assert property (@(posedge clk) disable iff (rst)
    (sp >= FULL_SP) && (sp <= EMPTY_SP));
  assert_push_step_R2: assert property (@(posedge clk) disable iff (rst)
    push_ok |=> sp == $past(sp) - 1'b1);
  assert_pop_step_R3: assert property (@(posedge clk) disable iff (rst)
    pop_ok |=> sp == $past(sp) + 1'b1);
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (push_req && sp == FULL_SP) |=> ($stable(sp) && ovf));
  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    (pop_req && sp == EMPTY_SP) |=> ($stable(sp) && unf));
  assert_unf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    unf |=> unf);
endmodule

// File: rtl/cs_stack_ram.sv
module cs_stack_ram #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 6,
  parameter int TOP_CELL = 239
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W = $clog2(DEPTH + 1);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(TOP_CELL - DEPTH + 1);

  logic [DATA_W-1:0] cells [DEPTH];
  logic [IDX_W-1:0]  wr_idx, rd_idx;

  assign wr_idx = IDX_W'(wr_addr - BASE);
  assign rd_idx = IDX_W'(rd_addr - BASE);

  always_ff @(posedge clk) begin
    if (we) cells[wr_idx] <= wr_data;
  end

  assign rd_data = (rd_idx < IDX_W'(DEPTH)) ? cells[rd_idx] : '0;

  assert_write_in_range_R6: assert property (@(posedge clk)
    we |-> (wr_idx < IDX_W'(DEPTH)));
endmodule

// File: rtl/cs_pc_unit.sv
module cs_pc_unit
  import cs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_e              cmd,
  input  logic              link_mode,
  input  logic              push_ok,
  input  logic              pop_ok,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] ret_addr,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] lr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      lr <= '0;
    end else begin
      unique case (cmd)
        CMD_STEP: pc <= pc + 1'b1;
        CMD_JMP:  pc <= target;
        CMD_CALL: begin
          if (link_mode) begin
            lr <= pc + 1'b1;
            pc <= target;
          end else if (push_ok) begin
            pc <= target;
          end
        end
        CMD_RET: begin
          if (link_mode)   pc <= lr;
          else if (pop_ok) pc <= ret_addr;
        end
        default: ;
      endcase
    end
  end

  assert_step_R9: assert property (@(posedge clk) disable iff (rst)
    cmd == CMD_STEP |=> pc == $past(pc) + 1'b1);
  assert_nop_R9: assert property (@(posedge clk) disable iff (rst)
    cmd == CMD_NOP |=> $stable(pc));
  assert_call_link_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_CALL && link_mode) |=> (lr == $past(pc) + 1'b1 && pc == $past(target)));
  assert_ret_stack_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_RET && !link_mode && pop_ok) |=> pc == $past(ret_addr));
  assert_call_blocked_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_CALL && !link_mode && !push_ok) |=> $stable(pc));
endmodule

// File: rtl/callstack_seq.sv
module callstack_seq
  import cs_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 6,
  parameter int TOP_CELL = 239
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmd,
  input  logic              link_mode,
  input  logic [ADDR_W-1:0] target,
  input  logic [DATA_W-1:0] din,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] dout,
  output logic [ADDR_W-1:0] lr,
  output logic              overflow,
  output logic              underflow
);
  cmd_e              op;
  logic              push_req, pop_req, push_ok, pop_ok;
  logic [ADDR_W-1:0] sp_dn;
  logic [DATA_W-1:0] wr_data, top_data;

  assign op       = cmd_e'(cmd);
  assign push_req = (op == CMD_PUSH) || (op == CMD_CALL && !link_mode);
  assign pop_req  = (op == CMD_POP)  || (op == CMD_RET  && !link_mode);
  assign sp_dn    = sp - 1'b1;
  assign wr_data  = (op == CMD_CALL) ? DATA_W'(pc + 1'b1) : din;
  assign mem_addr = push_req ? sp_dn : (pop_req ? sp : pc);

  cs_stack_ptr #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .TOP_CELL(TOP_CELL)) u_sp (
    .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
    .sp(sp), .push_ok(push_ok), .pop_ok(pop_ok), .ovf(overflow), .unf(underflow)
  );

  cs_stack_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .TOP_CELL(TOP_CELL)) u_ram (
    .clk(clk), .we(push_ok), .wr_addr(sp_dn), .wr_data(wr_data),
    .rd_addr(sp), .rd_data(top_data)
  );

  cs_pc_unit #(.ADDR_W(ADDR_W)) u_pc (
    .clk(clk), .rst(rst), .cmd(op), .link_mode(link_mode),
    .push_ok(push_ok), .pop_ok(pop_ok), .target(target),
    .ret_addr(ADDR_W'(top_data)), .pc(pc), .lr(lr)
  );

  always_ff @(posedge clk) begin
    if (rst)                          dout <= '0;
    else if (op == CMD_POP && pop_ok) dout <= top_data;
  end

  assert_pop_keeps_dout_R7: assert property (@(posedge clk) disable iff (rst)
    (op == CMD_POP && !pop_ok) |=> $stable(dout));
  assert_link_sp_R10: assert property (@(posedge clk) disable iff (rst)
    ((op == CMD_CALL || op == CMD_RET) && link_mode) |=> $stable(sp));
  assert_call_ret_R4: assert property (@(posedge clk) disable iff (rst)
    (op == CMD_CALL && !link_mode && push_ok) |=> (pc == $past(target) && sp == $past(sp) - 1'b1));
endmodule

// File: tb/sim_callstack_seq.sv
module sim_callstack_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] EMPTY_SP = 8'hF0;
  localparam logic [7:0] FULL_SP  = 8'hEA;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cmd = 3'd0;
  logic       link_mode = 1'b0;
  logic [7:0] target = 8'h00, din = 8'h00;
  logic [7:0] pc, sp, mem_addr, dout, lr;
  logic       overflow, underflow;

  int vectors = 0;
  int errors  = 0;

  logic [7:0] m_pc, m_sp, m_dout, m_lr;
  logic       m_ovf, m_unf;
  logic [7:0] m_mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  callstack_seq u0 (
    .clk(clk), .rst(rst), .cmd(cmd), .link_mode(link_mode), .target(target),
    .din(din), .pc(pc), .sp(sp), .mem_addr(mem_addr), .dout(dout), .lr(lr),
    .overflow(overflow), .underflow(underflow)
  );

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; cmd = 3'd0; link_mode = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    m_pc = 8'h00; m_sp = EMPTY_SP; m_dout = 8'h00; m_lr = 8'h00;
    m_ovf = 1'b0; m_unf = 1'b0;
    chk("R1", "pc", pc, 8'h00);
    chk("R1", "sp", sp, EMPTY_SP);
    chk("R1", "flags", {6'b0, overflow, underflow}, 8'h00);
    chk("R1", "dout", dout, 8'h00);
  endtask

  // Called at a falling edge; leaves at the next falling edge.
  task automatic do_cmd(input logic [2:0] c, input logic [7:0] t, input logic [7:0] d,
                        input logic lm, input string tag);
    logic [7:0] exp_addr;
    cmd = c; target = t; din = d; link_mode = lm;
    #1;
    if (c == 3'd5 || (c == 3'd3 && !lm))      exp_addr = m_sp - 8'd1;
    else if (c == 3'd6 || (c == 3'd4 && !lm)) exp_addr = m_sp;
    else                                      exp_addr = m_pc;
    chk("R8", "mem_addr", mem_addr, exp_addr);
    @(posedge clk);
    case (c)
      3'd1: m_pc = m_pc + 8'd1;
      3'd2: m_pc = t;
      3'd3: if (lm) begin m_lr = m_pc + 8'd1; m_pc = t; end
            else if (m_sp == FULL_SP) m_ovf = 1'b1;
            else begin m_sp = m_sp - 8'd1; m_mem[m_sp] = m_pc + 8'd1; m_pc = t; end
      3'd4: if (lm) m_pc = m_lr;
            else if (m_sp == EMPTY_SP) m_unf = 1'b1;
            else begin m_pc = m_mem[m_sp]; m_sp = m_sp + 8'd1; end
      3'd5: if (m_sp == FULL_SP) m_ovf = 1'b1;
            else begin m_sp = m_sp - 8'd1; m_mem[m_sp] = d; end
      3'd6: if (m_sp == EMPTY_SP) m_unf = 1'b1;
            else begin m_dout = m_mem[m_sp]; m_sp = m_sp + 8'd1; end
      default: ;
    endcase
    @(negedge clk);
    chk(tag, "pc", pc, m_pc);
    chk(tag, "sp", sp, m_sp);
    chk(tag, "dout", dout, m_dout);
    chk(tag, "lr", lr, m_lr);
    chk(tag, "overflow", {7'b0, overflow}, {7'b0, m_ovf});
    chk(tag, "underflow", {7'b0, underflow}, {7'b0, m_unf});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R3: LIFO order with literal expectations
    do_cmd(3'd5, 8'h00, 8'd7, 1'b0, "R2");
    chk("R2", "first push address", sp, 8'hEF);
    do_cmd(3'd5, 8'h00, 8'd3, 1'b0, "R2");
    do_cmd(3'd5, 8'h00, 8'd9, 1'b0, "R2");
    do_cmd(3'd5, 8'h00, 8'd5, 1'b0, "R2");
    do_cmd(3'd6, 8'h00, 8'h00, 1'b0, "R3"); chk("R3", "lifo1", dout, 8'd5);
    do_cmd(3'd6, 8'h00, 8'h00, 1'b0, "R3"); chk("R3", "lifo2", dout, 8'd9);
    do_cmd(3'd6, 8'h00, 8'h00, 1'b0, "R3"); chk("R3", "lifo3", dout, 8'd3);
    do_cmd(3'd6, 8'h00, 8'h00, 1'b0, "R3"); chk("R3", "lifo4", dout, 8'd7);

    // R7: underflow on empty stack by POP and by RET
    do_cmd(3'd2, 8'h33, 8'h00, 1'b0, "R9");
    do_cmd(3'd6, 8'h00, 8'h00, 1'b0, "R7");
    do_cmd(3'd4, 8'h00, 8'h00, 1'b0, "R7");
    chk("R7", "pc kept", pc, 8'h33);
    chk("R7", "sp kept", sp, EMPTY_SP);

    // R6: fill with pushes, seventh suppressed, contents intact
    do_reset();
    for (int i = 0; i < 7; i++) do_cmd(3'd5, 8'h00, 8'(i * 17 + 1), 1'b0, "R6");
    chk("R6", "sp at limit", sp, FULL_SP);
    chk("R6", "overflow set", {7'b0, overflow}, 8'h01);
    for (int i = 5; i >= 0; i--) begin
      do_cmd(3'd6, 8'h00, 8'h00, 1'b0, "R6");
      chk("R6", "content kept", dout, 8'(i * 17 + 1));
    end

    // R4/R5/R6: every nesting depth from 1 to 7
    for (int n = 1; n <= 7; n++) begin
      do_reset();
      do_cmd(3'd2, 8'h10, 8'h00, 1'b0, "R9");
      for (int k = 0; k < n; k++) do_cmd(3'd3, 8'(8'h20 + k * 16), 8'h00, 1'b0, "R4");
      for (int k = 0; k < n; k++) do_cmd(3'd4, 8'h00, 8'h00, 1'b0, "R5");
    end
    chk("R5", "outermost return", pc, 8'h11);

    // R9: full PC wrap
    do_reset();
    for (int i = 0; i < 256; i++) do_cmd(3'd1, 8'h00, 8'h00, 1'b0, "R9");
    chk("R9", "wrap", pc, 8'h00);
    do_cmd(3'd0, 8'h77, 8'h00, 1'b0, "R9");

    // R10: link register nesting loses the outer return
    do_reset();
    do_cmd(3'd2, 8'h40, 8'h00, 1'b1, "R10");
    do_cmd(3'd3, 8'h80, 8'h00, 1'b1, "R10");
    chk("R10", "lr first", lr, 8'h41);
    do_cmd(3'd3, 8'hA0, 8'h00, 1'b1, "R10");
    do_cmd(3'd4, 8'h00, 8'h00, 1'b1, "R10");
    chk("R10", "inner return", pc, 8'h81);
    do_cmd(3'd4, 8'h00, 8'h00, 1'b1, "R10");
    chk("R10", "outer lost", pc, 8'h81);
    chk("R10", "sp untouched", sp, EMPTY_SP);

    // Mixed arithmetic sweep over all commands and both modes
    do_reset();
    for (int i = 0; i < 400; i++)
      do_cmd(3'((i * 5 + 3) % 7), 8'(i * 29 + 5), 8'(i * 13), 1'((i / 11) % 2), "R8");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule